// File: doc/BRIEF.md
# Periodic Interrupt and Watchdog Timer

This block turns a slow clock-enable tick (nominally 32.768 kHz) into either a periodic interrupt or a watchdog timeout. Both functions use one binary divider. A 3-bit rate code selects the interrupt rate. In the default build the codes 0 to 7 give 1, 2, 4, 8, 16, 32, 64 and 128 Hz. In timer routing, each completed divider period produces a short low pulse on the interrupt line. In watchdog routing, a 2-bit stage counts completed periods. When it counts four periods without being cleared, it latches a timeout flag, and that flag pulls the interrupt line low.

A command decoder controls the block with single-cycle strobes. The strobes switch the system clock domain on and off, start and stop the divider, choose between timer and watchdog routing, clear the divider or the watchdog, enable and disable the interrupt output, and load a new rate code. The interrupt pin is open-drain. It is modelled as a pull-low request plus an output enable, and the pin floats whenever the output enable is low.

Top module: `tbwd_top`

## Requirements
- R1: After reset, irq_oe and irq_pull_low are 0, the system is off, the divider is stopped, timer routing is selected and the rate code is 7.
- R2: With rate code c, one divider period lasts 2^(DIV_LOG2-c) counted ticks. The divider is not reset between periods, so periods follow one another back to back.
- R3: In timer routing with the interrupt enabled, the tick that completes a period makes irq_pull_low 1 from the next cycle. It returns to 0 in the cycle after the next tick.
- R4: In watchdog routing, the timeout flag sets on the fourth period completed since the last watchdog clear. While the interrupt is enabled, irq_pull_low then stays 1 until the flag is cleared.
- R5: cmd_wd_clr zeroes the divider, the watchdog stage and the timeout flag. cmd_tb_clr zeroes only the divider. Either clear removes a pending timer pulse. If a clear arrives in the same cycle as a counting tick, the clear wins and that tick completes no period.
- R6: cmd_wd_route starts the divider and selects watchdog routing. cmd_tb_route starts the divider and selects timer routing. cmd_wd_stop and cmd_tb_stop stop the divider and hold its count. A stop beats a start in the same cycle, and watchdog routing beats timer routing in the same cycle.
- R7: cmd_irq_on sets irq_oe from the next cycle. cmd_irq_off clears irq_oe and the timeout flag, and it wins if both arrive in the same cycle. irq_pull_low is never 1 while irq_oe is 0.
- R8: While the system is off, the divider and the watchdog stage hold their values. cmd_sys_on resumes counting from the held count. cmd_sys_off wins over cmd_sys_on in the same cycle.
- R9: A cycle without tick_en never advances the divider, even when the divider is running.
- R10: cmd_rate_ld loads cmd_rate without clearing the divider. The next period completes when the counter's low DIV_LOG2-c bits next wrap to zero under the new code c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow-clock tick enable, one cycle wide |
| cmd_sys_on | input | 1 | Strobe: system clock on |
| cmd_sys_off | input | 1 | Strobe: system clock off |
| cmd_tb_route | input | 1 | Strobe: start divider, timer routing |
| cmd_tb_stop | input | 1 | Strobe: stop divider |
| cmd_wd_route | input | 1 | Strobe: start divider, watchdog routing |
| cmd_wd_stop | input | 1 | Strobe: stop divider |
| cmd_tb_clr | input | 1 | Strobe: clear divider |
| cmd_wd_clr | input | 1 | Strobe: clear divider, watchdog stage and flag |
| cmd_irq_on | input | 1 | Strobe: enable interrupt output |
| cmd_irq_off | input | 1 | Strobe: disable interrupt output, drop flag |
| cmd_rate_ld | input | 1 | Strobe: load rate code |
| cmd_rate | input | 3 | Rate code, 0 slowest to 7 fastest |
| irq_pull_low | output | 1 | Request to drive the interrupt pin low |
| irq_oe | output | 1 | Interrupt pin driver enable |

## Verification
The main collision is between a clear and the tick that would complete a divider period. The bench provokes it by issuing cmd_tb_clr every eight cycles at the fastest rate, so every clear lands on the wrapping tick and no pulse may appear. It repeats the collision with cmd_wd_clr on the tick that would complete the fourth watchdog period. A second collision is cmd_irq_off landing together with a timeout. In every case a behavioural model that gives the clear priority is compared with both outputs on every cycle.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;

    localparam int RATE_W = 3;

    typedef enum logic {
        ROUTE_TB = 1'b0,
        ROUTE_WD = 1'b1
    } route_e;

    typedef struct packed {
        logic              sys_on;
        logic              sys_off;
        logic              tb_route;
        logic              tb_stop;
        logic              wd_route;
        logic              wd_stop;
        logic              tb_clr;
        logic              wd_clr;
        logic              irq_on;
        logic              irq_off;
        logic              rate_ld;
        logic [RATE_W-1:0] rate;
    } cmd_t;

    typedef struct packed {
        logic              sys_on;
        logic              run;
        route_e            route;
        logic              irq_en;
        logic [RATE_W-1:0] rate;
    } ctl_t;

endpackage

// File: rtl/tbwd_ctrl.sv
module tbwd_ctrl
    import tbwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_t cmd,
    output ctl_t ctl
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        // system clock domain: off has priority
        if (cmd.sys_off)      ctl_d.sys_on = 1'b0;
        else if (cmd.sys_on)  ctl_d.sys_on = 1'b1;
        // divider run state: any stop has priority over any start
        if (cmd.wd_stop || cmd.tb_stop)        ctl_d.run = 1'b0;
        else if (cmd.wd_route || cmd.tb_route) ctl_d.run = 1'b1;
        // routing: watchdog has priority
        if (cmd.wd_route)      ctl_d.route = ROUTE_WD;
        else if (cmd.tb_route) ctl_d.route = ROUTE_TB;
        // interrupt output enable: off has priority
        if (cmd.irq_off)      ctl_d.irq_en = 1'b0;
        else if (cmd.irq_on)  ctl_d.irq_en = 1'b1;
        if (cmd.rate_ld)      ctl_d.rate = cmd.rate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.sys_on <= 1'b0;
            ctl_q.run    <= 1'b0;
            ctl_q.route  <= ROUTE_TB;
            ctl_q.irq_en <= 1'b0;
            ctl_q.rate   <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/tbwd_div.sv
module tbwd_div
    import tbwd_pkg::*;
#(
    parameter int DIV_LOG2 = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic              period_ev
);

    localparam int CNT_W = DIV_LOG2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t             div_d, div_q;
    logic [CNT_W-1:0] span_mask;
    logic             wrap;

    always_comb begin
        // low bits that must all be set for the next tick to close a period
        span_mask = {CNT_W{1'b1}} >> rate;
        wrap      = ((div_q.cnt & span_mask) == span_mask);
        div_d     = div_q;
        period_ev = 1'b0;
        if (clear) begin
            div_d.cnt = '0;
        end else if (advance) begin
            div_d.cnt = div_q.cnt + 1'b1;
            period_ev = wrap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/tbwd_wdog.sv
module tbwd_wdog #(
    parameter int WD_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic clr_all,
    input  logic clr_flag,
    output logic flag
);

    localparam logic [WD_W-1:0] LAST = {WD_W{1'b1}};

    typedef struct packed {
        logic [WD_W-1:0] stage;
        logic            flag;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (clr_all) begin
            wd_d.stage = '0;
            wd_d.flag  = 1'b0;
        end else if (count_en) begin
            wd_d.stage = wd_q.stage + 1'b1;
            if (wd_q.stage == LAST) wd_d.flag = 1'b1;
        end
        if (clr_flag) wd_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign flag = wd_q.flag;

endmodule

// File: rtl/tbwd_irq.sv
module tbwd_irq
    import tbwd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   mark,
    input  logic   clear,
    input  route_e route,
    input  logic   irq_en,
    input  logic   wd_flag,
    output logic   pull_low,
    output logic   oe
);

    typedef struct packed {
        logic pulse;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (clear)     irq_d.pulse = 1'b0;
        else if (mark) irq_d.pulse = 1'b1;
        else if (tick) irq_d.pulse = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign oe       = irq_en;
    assign pull_low = irq_en & ((route == ROUTE_WD) ? wd_flag : irq_q.pulse);

endmodule

// File: rtl/tbwd_top.sv
module tbwd_top
    import tbwd_pkg::*;
#(
    parameter int DIV_LOG2 = 15,
    parameter int WD_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              cmd_sys_on,
    input  logic              cmd_sys_off,
    input  logic              cmd_tb_route,
    input  logic              cmd_tb_stop,
    input  logic              cmd_wd_route,
    input  logic              cmd_wd_stop,
    input  logic              cmd_tb_clr,
    input  logic              cmd_wd_clr,
    input  logic              cmd_irq_on,
    input  logic              cmd_irq_off,
    input  logic              cmd_rate_ld,
    input  logic [RATE_W-1:0] cmd_rate,
    output logic              irq_pull_low,
    output logic              irq_oe
);

    cmd_t   cmd;
    ctl_t   ctl;
    logic   sys_on;
    logic   irq_en;
    route_e route;
    logic   advance;
    logic   div_clear;
    logic   period_ev;
    logic   wd_flag;

    assign cmd = '{sys_on:   cmd_sys_on,   sys_off:  cmd_sys_off,
                   tb_route: cmd_tb_route, tb_stop:  cmd_tb_stop,
                   wd_route: cmd_wd_route, wd_stop:  cmd_wd_stop,
                   tb_clr:   cmd_tb_clr,   wd_clr:   cmd_wd_clr,
                   irq_on:   cmd_irq_on,   irq_off:  cmd_irq_off,
                   rate_ld:  cmd_rate_ld,  rate:     cmd_rate};

    tbwd_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .ctl   (ctl)
    );

    assign sys_on    = ctl.sys_on;
    assign irq_en    = ctl.irq_en;
    assign route     = ctl.route;
    assign advance   = tick_en & ctl.sys_on & ctl.run;
    assign div_clear = cmd_tb_clr | cmd_wd_clr;

    tbwd_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .clear     (div_clear),
        .rate      (ctl.rate),
        .period_ev (period_ev)
    );

    tbwd_wdog #(.WD_W(WD_W)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (period_ev & (route == ROUTE_WD)),
        .clr_all  (cmd_wd_clr),
        .clr_flag (cmd_irq_off),
        .flag     (wd_flag)
    );

    tbwd_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .mark     (period_ev & (route == ROUTE_TB)),
        .clear    (div_clear),
        .route    (route),
        .irq_en   (irq_en),
        .wd_flag  (wd_flag),
        .pull_low (irq_pull_low),
        .oe       (irq_oe)
    );

endmodule

// File: rtl/tbwd_chk.sv
module tbwd_chk
    import tbwd_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   tick_en,
    input logic   cmd_wd_clr,
    input logic   cmd_irq_on,
    input logic   cmd_irq_off,
    input logic   cmd_tb_route,
    input logic   sys_on,
    input route_e route,
    input logic   period_ev,
    input logic   wd_flag,
    input logic   irq_pull_low,
    input logic   irq_oe
);

    assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq_off |=> !irq_oe && !irq_pull_low);

    assert_irq_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq_on && !cmd_irq_off |=> irq_oe);

    assert_low_needs_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_low |-> irq_oe);

    assert_wd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wd_clr |=> !wd_flag);

    assert_flag_from_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $past(period_ev) && $past(route) == ROUTE_WD);

    assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wd_flag && route == ROUTE_WD && irq_oe && !cmd_wd_clr && !cmd_irq_off
        && !cmd_tb_route |=> irq_pull_low);

    assert_sys_off_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_on |-> !period_ev);

    assert_no_tick_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |-> !period_ev);

endmodule

bind tbwd_top tbwd_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .cmd_wd_clr   (cmd_wd_clr),
    .cmd_irq_on   (cmd_irq_on),
    .cmd_irq_off  (cmd_irq_off),
    .cmd_tb_route (cmd_tb_route),
    .sys_on       (sys_on),
    .route        (route),
    .period_ev    (period_ev),
    .wd_flag      (wd_flag),
    .irq_pull_low (irq_pull_low),
    .irq_oe       (irq_oe)
);

// File: tb/tb_tbwd_top.sv
module tb_tbwd_top;

    localparam int DIVL = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b1;
    logic s_sys_on = 0, s_sys_off = 0, s_tb_route = 0, s_tb_stop = 0;
    logic s_wd_route = 0, s_wd_stop = 0, s_tb_clr = 0, s_wd_clr = 0;
    logic s_irq_on = 0, s_irq_off = 0, s_rate_ld = 0;
    logic [2:0] s_rate = 3'd0;
    logic irq_pull_low, irq_oe;

    always #2.5 clk = ~clk;

    tbwd_top #(.DIV_LOG2(DIVL), .WD_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cmd_sys_on(s_sys_on), .cmd_sys_off(s_sys_off),
        .cmd_tb_route(s_tb_route), .cmd_tb_stop(s_tb_stop),
        .cmd_wd_route(s_wd_route), .cmd_wd_stop(s_wd_stop),
        .cmd_tb_clr(s_tb_clr), .cmd_wd_clr(s_wd_clr),
        .cmd_irq_on(s_irq_on), .cmd_irq_off(s_irq_off),
        .cmd_rate_ld(s_rate_ld), .cmd_rate(s_rate),
        .irq_pull_low(irq_pull_low), .irq_oe(irq_oe)
    );

    // behavioural reference state
    bit m_sys = 0, m_run = 0, m_wd = 0, m_irq = 0, m_flag = 0, m_pulse = 0;
    int m_rate = 7, m_cnt = 0, m_wc = 0;
    int vectors = 0, miscompares = 0;
    bit gap = 0;
    string cur_req = "R1";

    task automatic model_step();
        bit clr, ev;
        int per;
        clr = s_tb_clr || s_wd_clr;
        ev  = 0;
        if (clr) m_cnt = 0;
        else if (m_sys && m_run && tick_en) begin
            per   = 1 << (DIVL - m_rate);
            ev    = ((m_cnt + 1) % per) == 0;
            m_cnt = (m_cnt + 1) % (1 << DIVL);
        end
        if (s_wd_clr) begin m_wc = 0; m_flag = 0; end
        else if (ev && m_wd) begin
            if (m_wc == 3) m_flag = 1;
            m_wc = (m_wc + 1) % 4;
        end
        if (s_irq_off) m_flag = 0;
        if (clr) m_pulse = 0;
        else if (ev && !m_wd) m_pulse = 1;
        else if (tick_en) m_pulse = 0;
        if (s_sys_off) m_sys = 0; else if (s_sys_on) m_sys = 1;
        if (s_wd_stop || s_tb_stop) m_run = 0;
        else if (s_wd_route || s_tb_route) m_run = 1;
        if (s_wd_route) m_wd = 1; else if (s_tb_route) m_wd = 0;
        if (s_irq_off) m_irq = 0; else if (s_irq_on) m_irq = 1;
        if (s_rate_ld) m_rate = s_rate;
    endtask

    task automatic compare();
        bit e_low;
        e_low = m_irq && (m_wd ? m_flag : m_pulse);
        vectors++;
        if (irq_oe !== m_irq || irq_pull_low !== e_low) begin
            miscompares++;
            $display("FAIL %s t=%0t: oe=%0b low=%0b expected oe=%0b low=%0b",
                     cur_req, $time, irq_oe, irq_pull_low, m_irq, e_low);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
            {s_sys_on, s_sys_off, s_tb_route, s_tb_stop, s_wd_route, s_wd_stop,
             s_tb_clr, s_wd_clr, s_irq_on, s_irq_off, s_rate_ld} = '0;
            tick_en = gap ? ~tick_en : 1'b1;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, nothing enabled
        cur_req = "R1"; cyc(6);
        // bring-up in timer routing at the fastest rate
        cur_req = "R6"; s_sys_on = 1; cyc(1);
        s_irq_on = 1; cyc(1);
        s_tb_clr = 1; s_tb_route = 1; cyc(1);
        cur_req = "R3"; cyc(40);
        cur_req = "R2"; s_rate_ld = 1; s_rate = 3'd5; cyc(1); cyc(100);
        // R10: load a new rate mid-period without clearing
        cur_req = "R10"; cyc(13); s_rate_ld = 1; s_rate = 3'd6; cyc(1); cyc(60);
        // R9: ticks only every other cycle
        cur_req = "R9"; gap = 1; cyc(90); gap = 0; tick_en = 1; cyc(2);
        // R5: timer clear lands on every wrapping tick at rate 7
        cur_req = "R5"; s_rate_ld = 1; s_rate = 3'd7; s_tb_clr = 1; cyc(1);
        for (int k = 0; k < 8; k++) begin cyc(7); s_tb_clr = 1; cyc(1); end
        cyc(20);
        // R8: system off freezes, on resumes; off wins over on
        cur_req = "R8"; cyc(3); s_sys_off = 1; cyc(1); cyc(30);
        s_sys_on = 1; s_sys_off = 1; cyc(1); cyc(10);
        s_sys_on = 1; cyc(1); cyc(25);
        // R6: stop holds, restart resumes; stop beats start
        cur_req = "R6"; s_tb_stop = 1; cyc(1); cyc(20);
        s_tb_route = 1; s_wd_stop = 1; cyc(1); cyc(10);
        s_tb_route = 1; cyc(1); cyc(20);
        // R4: watchdog routing, timeout after four periods, held low
        cur_req = "R4"; s_wd_clr = 1; s_wd_route = 1; s_tb_route = 1; cyc(1); cyc(70);
        s_wd_clr = 1; cyc(1); cyc(45);
        // R5: watchdog clear on the tick closing the fourth period
        cur_req = "R5"; s_wd_clr = 1; cyc(1); cyc(31); s_wd_clr = 1; cyc(1); cyc(40);
        // R7: interrupt off drops flag and oe; off wins over on
        cur_req = "R7"; cyc(5); s_irq_off = 1; s_irq_on = 1; cyc(1); cyc(10);
        s_irq_on = 1; cyc(1); cyc(40); s_irq_off = 1; cyc(1); cyc(5);
        s_irq_on = 1; s_wd_clr = 1; cyc(1); cyc(10);
        // R2: slowest rate in watchdog routing, four periods of 1024 ticks
        cur_req = "R2"; s_rate_ld = 1; s_rate = 3'd0; s_wd_clr = 1; cyc(1);
        cyc(4200);
        // back to timer routing at rate 0, one long period
        cur_req = "R3"; s_tb_route = 1; s_tb_clr = 1; cyc(1); cyc(1100);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule